// File: doc/BRIEF.md
# Data Cache Line Maintenance Unit

This unit carries out software cache-maintenance commands on a small direct-mapped data cache. The pipeline presents one instruction word with two register operands, a user-mode flag and a few static configuration bits. The unit decodes which variant was asked for and forms the target line address. It then either discards the line, writes it back and drops it, or forwards an invalidate or flush request to an external cache. The cache state is a tag array with valid and dirty bits and 16 lines of four 32-bit words each. A refill port installs lines from outside, and a valid/ready port carries the dirty words out to memory.

Each accepted command ends in exactly one single-cycle pulse: completion, privilege exception or illegal encoding. The unit accepts the next command only when it is idle again.

Top module: `cmaint_unit`

## Requirements
- R1: The word is numbered MSB-first, so word bit n is `cmdWord[31-n]`. The fixed fields must read opcode 100100 in bits 0-5, zeros in bits 6-10, 22, 23 and 28, ones in bits 25, 26 and 29, and zero in bit 31. The modifier bits are E at bit 21, EA at 24, F at 27 and T at 30. With these fields the six variant words are 0x90000064, 0x90000074, 0x90000066, 0x900000E6, 0x90000476 and 0x90000466. Any other value in a fixed field gives an illegal pulse and leaves the cache unchanged.
- R2: When the MMU option is on and userMode is 1, a correctly encoded command changes nothing, produces no memory or external traffic, and gives a privExc pulse instead of done.
- R3: In write-back mode with F set, the line indexed by opA+opB is written out if it is valid and dirty. The four words go in ascending order, with addresses built from the stored tag and index, and a beat advances only when memReady is high. The line is invalidated after the last beat is accepted.
- R4: In write-back mode with F set on a clean or invalid line, no memory traffic occurs and the line is invalidated.
- R5: In write-back mode with F and T clear, the line indexed by opA+opB is invalidated whatever its tag, and its dirty data is discarded without write-back.
- R6: In write-back mode with T set, the line is invalidated only when its stored tag equals the tag of the target address. On a mismatch the line is left untouched.
- R7: In write-back mode with T set, the target address is {opA,opB} cut to 40 bits when EA is set and cfgExtAddr is 1. Otherwise it is opA+opB. The E bit has no effect in write-back mode.
- R8: In write-back mode, F and T both set gives an illegal pulse and no cache change.
- R9: In write-through mode with E clear, or with E set while cfgExtCache is 0, the line indexed by opA alone is invalidated and opB is ignored.
- R10: In write-through mode with E set and cfgExtCache 1, one external request is raised. Its address is opA+opB and extFlush equals F. The request stays up until extReady, and the internal line at that index is then invalidated.
- R11: done, privExc and illegal are one-cycle pulses, exactly one per command. done comes the cycle after the last change, which is the final beat or the external handshake. cmdReady is low from acceptance until that pulse.
- R12: A fill installs tag, data and dirty bit into the line indexed by fillAddr[7:4] and marks it valid. When a fill and an invalidation hit the same line in the same cycle, the fill wins.
- R13: After reset every line is invalid, cmdReady is 1, and memValid, extValid and all three result pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Unit idle, command taken this cycle |
| cmdWord | input | 32 | Maintenance instruction word |
| opA | input | 32 | First register operand |
| opB | input | 32 | Second register operand |
| userMode | input | 1 | Issuing context is user mode |
| cfgWriteBack | input | 1 | Cache runs in write-back mode |
| cfgMmu | input | 1 | MMU present (privilege checking on) |
| cfgExtAddr | input | 1 | Extended addressing enabled |
| cfgExtCache | input | 1 | External-cache interconnect enabled |
| fillEn | input | 1 | Install a line |
| fillAddr | input | 40 | Line address of the installed line |
| fillDirty | input | 1 | Installed line is dirty |
| fillData | input | 128 | Four words, word 0 in the low bits |
| memValid | output | 1 | Write-back beat valid |
| memReady | input | 1 | Memory accepts the beat |
| memAddr | output | 40 | Byte address of the beat |
| memData | output | 32 | Beat data |
| extValid | output | 1 | External-cache request valid |
| extReady | input | 1 | External cache accepts |
| extFlush | output | 1 | 1 = flush, 0 = invalidate |
| extAddr | output | 40 | External request address |
| done | output | 1 | Command completed |
| privExc | output | 1 | Privileged-instruction exception |
| illegal | output | 1 | Illegal encoding or F/T combination |

## Verification
A refill through the fill port can land on the same line, in the same cycle, as the invalidation that a maintenance command performs. The bench installs a dirty line and issues an index-only invalidate at that line. It then raises a fill with a new tag and new data one cycle after acceptance, which is the decision cycle. A following flush must write out the new tag and data, which shows the fill took priority. Write-back beats are also run against a memReady that stalls every other cycle, so the point at which the line is invalidated is tested under back-pressure.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;
  // decoded maintenance action
  typedef enum logic [2:0] {
    ACT_ILL, ACT_PRIV, ACT_INV_IDX, ACT_INV_TAG, ACT_FLUSH, ACT_EXT
  } act_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clrLine;
    logic beatInc;
  } strobe_t;
endpackage

// File: rtl/cmaint_dpath.sv
module cmaint_dpath
  import cmaint_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int LINES = 16,
  parameter int WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [31:0]           cmdWord,
  input  logic [31:0]           opA,
  input  logic [31:0]           opB,
  input  logic                  userMode,
  input  logic                  cfgWriteBack,
  input  logic                  cfgMmu,
  input  logic                  cfgExtAddr,
  input  logic                  cfgExtCache,
  input  logic                  fillEn,
  input  logic [PA_W-1:0]       fillAddr,
  input  logic                  fillDirty,
  input  logic [WORDS*32-1:0]   fillData,
  output act_e                  act,
  output logic                  lineDirty,
  output logic                  tagHit,
  output logic                  lastBeat,
  output logic                  extFlush,
  output logic [PA_W-1:0]       extAddr,
  output logic [PA_W-1:0]       memAddr,
  output logic [31:0]           memData
);
  localparam int IDX_W = $clog2(LINES);
  localparam int BEAT_W = $clog2(WORDS);
  localparam int OFF_W = BEAT_W + 2;
  localparam int TAG_W = PA_W - IDX_W - OFF_W;

  // word fields, MSB-first bit n lives at cmdWord[31-n]
  logic bitE, bitEa, bitF, bitT, fixedOk;
  assign bitE  = cmdWord[10];
  assign bitEa = cmdWord[7];
  assign bitF  = cmdWord[4];
  assign bitT  = cmdWord[1];
  assign fixedOk = (cmdWord[31:26] == 6'b100100) && (cmdWord[25:21] == 5'd0)
                && (cmdWord[9:8] == 2'b00) && (cmdWord[6:5] == 2'b11)
                && (cmdWord[3:2] == 2'b01) && !cmdWord[0];

  logic [31:0] sum32;
  logic [63:0] catFull;
  logic [PA_W-1:0] sumAddr, catAddr, rAAddr;
  assign sum32   = opA + opB;
  assign catFull = {opA, opB};
  assign sumAddr = PA_W'(sum32);
  assign catAddr = catFull[PA_W-1:0];
  assign rAAddr  = PA_W'(opA);

  act_e actD;
  logic [PA_W-1:0] addrD;
  always_comb begin
    actD  = ACT_INV_IDX;
    addrD = sumAddr;
    if (!fixedOk)                 actD = ACT_ILL;
    else if (cfgMmu && userMode)  actD = ACT_PRIV;
    else if (cfgWriteBack) begin
      if (bitF && bitT)           actD = ACT_ILL;
      else if (bitF)              actD = ACT_FLUSH;
      else if (bitT) begin
        actD = ACT_INV_TAG;
        if (bitEa && cfgExtAddr) addrD = catAddr;
      end
    end else if (bitE && cfgExtCache) actD = ACT_EXT;
    else addrD = rAAddr;
  end

  logic [PA_W-1:0] addrQ;
  logic flushQ;
  logic [BEAT_W-1:0] beatQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      act <= ACT_ILL; addrQ <= '0; flushQ <= 1'b0; beatQ <= '0;
    end else if (stb.capture) begin
      act <= actD; addrQ <= addrD; flushQ <= bitF; beatQ <= '0;
    end else if (stb.beatInc) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  // line storage
  logic [LINES-1:0] validArr, dirtyArr;
  logic [TAG_W-1:0] tagArr [LINES];
  logic [31:0]      dataArr [LINES][WORDS];

  logic [IDX_W-1:0] lineIdx, fillIdx;
  logic [TAG_W-1:0] lineTag;
  assign lineIdx = addrQ[OFF_W +: IDX_W];
  assign lineTag = addrQ[PA_W-1 -: TAG_W];
  assign fillIdx = fillAddr[OFF_W +: IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr <= '0; dirtyArr <= '0;
    end else begin
      if (stb.clrLine) begin
        validArr[lineIdx] <= 1'b0;
        dirtyArr[lineIdx] <= 1'b0;
      end
      if (fillEn) begin  // a same-cycle fill overrides the clear
        validArr[fillIdx] <= 1'b1;
        dirtyArr[fillIdx] <= fillDirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      tagArr[fillIdx] <= fillAddr[PA_W-1 -: TAG_W];
      for (int w = 0; w < WORDS; w++) dataArr[fillIdx][w] <= fillData[w*32 +: 32];
    end
  end

  assign tagHit    = (tagArr[lineIdx] == lineTag);
  assign lineDirty = validArr[lineIdx] & dirtyArr[lineIdx];
  assign lastBeat  = (beatQ == BEAT_W'(WORDS-1));
  assign memAddr   = {tagArr[lineIdx], lineIdx, beatQ, 2'b00};
  assign memData   = dataArr[lineIdx][beatQ];
  assign extAddr   = addrQ;
  assign extFlush  = flushQ;

  // control never advances past the final beat
  assert_beat_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.beatInc |-> !lastBeat);
endmodule

// File: rtl/cmaint_ctrl.sv
module cmaint_ctrl
  import cmaint_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  act_e    act,
  input  logic    lineDirty,
  input  logic    tagHit,
  input  logic    lastBeat,
  input  logic    memReady,
  input  logic    extReady,
  output strobe_t stb,
  output logic    cmdReady,
  output logic    memValid,
  output logic    extValid,
  output logic    done,
  output logic    privExc,
  output logic    illegal
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WB, S_EXT} st_e;
  st_e st, stN;
  logic doneN, privN, illN;

  always_comb begin
    stN = st; stb = '0; doneN = 1'b0; privN = 1'b0; illN = 1'b0;
    cmdReady = (st == S_IDLE);
    memValid = (st == S_WB);
    extValid = (st == S_EXT);
    case (st)
      S_IDLE: if (cmdValid) begin stb.capture = 1'b1; stN = S_EXEC; end
      S_EXEC: begin
        stN = S_IDLE;
        case (act)
          ACT_PRIV:    privN = 1'b1;
          ACT_ILL:     illN = 1'b1;
          ACT_INV_TAG: begin stb.clrLine = tagHit; doneN = 1'b1; end
          ACT_FLUSH:   if (lineDirty) stN = S_WB;
                       else begin stb.clrLine = 1'b1; doneN = 1'b1; end
          ACT_EXT:     stN = S_EXT;
          default:     begin stb.clrLine = 1'b1; doneN = 1'b1; end
        endcase
      end
      S_WB: if (memReady) begin
        if (lastBeat) begin stb.clrLine = 1'b1; doneN = 1'b1; stN = S_IDLE; end
        else stb.beatInc = 1'b1;
      end
      S_EXT: if (extReady) begin stb.clrLine = 1'b1; doneN = 1'b1; stN = S_IDLE; end
      default: stN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; done <= 1'b0; privExc <= 1'b0; illegal <= 1'b0;
    end else begin
      st <= stN; done <= doneN; privExc <= privN; illegal <= illN;
    end
  end

  assert_one_result_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, privExc, illegal}));
  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid);
endmodule

// File: rtl/cmaint_unit.sv
module cmaint_unit
  import cmaint_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int LINES = 16,
  parameter int WORDS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [31:0]         cmdWord,
  input  logic [31:0]         opA,
  input  logic [31:0]         opB,
  input  logic                userMode,
  input  logic                cfgWriteBack,
  input  logic                cfgMmu,
  input  logic                cfgExtAddr,
  input  logic                cfgExtCache,
  input  logic                fillEn,
  input  logic [PA_W-1:0]     fillAddr,
  input  logic                fillDirty,
  input  logic [WORDS*32-1:0] fillData,
  output logic                memValid,
  input  logic                memReady,
  output logic [PA_W-1:0]     memAddr,
  output logic [31:0]         memData,
  output logic                extValid,
  input  logic                extReady,
  output logic                extFlush,
  output logic [PA_W-1:0]     extAddr,
  output logic                done,
  output logic                privExc,
  output logic                illegal
);
  strobe_t stb;
  act_e act;
  logic lineDirty, tagHit, lastBeat;

  cmaint_ctrl uCtrl (
    .clk, .rstN, .cmdValid, .act, .lineDirty, .tagHit, .lastBeat,
    .memReady, .extReady, .stb, .cmdReady, .memValid, .extValid,
    .done, .privExc, .illegal
  );

  cmaint_dpath #(.PA_W(PA_W), .LINES(LINES), .WORDS(WORDS)) uDpath (
    .clk, .rstN, .stb, .cmdWord, .opA, .opB, .userMode, .cfgWriteBack,
    .cfgMmu, .cfgExtAddr, .cfgExtCache, .fillEn, .fillAddr, .fillDirty,
    .fillData, .act, .lineDirty, .tagHit, .lastBeat, .extFlush, .extAddr,
    .memAddr, .memData
  );

  assert_ext_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    extValid && !extReady |=> extValid && $stable(extFlush) && $stable(extAddr));
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (privExc || illegal) |-> $past(!memValid && !extValid));
endmodule

// File: tb/tb_cmaint_unit.sv
module tb_cmaint_unit;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 0, userMode = 0, fillEn = 0, fillDirty = 0;
  logic cfgWriteBack = 0, cfgMmu = 0, cfgExtAddr = 0, cfgExtCache = 0;
  logic [31:0] cmdWord = '0, opA = '0, opB = '0;
  logic [39:0] fillAddr = '0;
  logic [127:0] fillData = '0;
  logic memReady = 0, extReady = 0;
  logic cmdReady, memValid, extValid, extFlush, done, privExc, illegal;
  logic [39:0] memAddr, extAddr;
  logic [31:0] memData;

  always #2 clk = ~clk;  // 250 MHz

  cmaint_unit dut (.*);

  localparam logic [31:0] W_INV = 32'h90000064, W_FL = 32'h90000074,
    W_CLR = 32'h90000066, W_CLREA = 32'h900000E6, W_XFL = 32'h90000476,
    W_XCLR = 32'h90000466, W_EF = 32'h90000474, W_BAD = 32'h94000064;

  // cfg = {writeBack, mmu, extAddr, extCache}; res 0 done,1 priv,2 illegal
  // ext 0 none,1 invalidate,2 flush
  typedef struct packed {
    logic [39:0] fAddr; logic fDirty; logic [3:0] cfg; logic usr;
    logic [31:0] iw; logic [31:0] ra; logic [31:0] rb;
    logic [1:0] res; logic wb; logic [1:0] ext; logic [39:0] extA; logic alive;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{40'h0012345670, 1'b1, 4'b1000, 1'b0, W_FL,    32'h12345600, 32'h70,       2'd0, 1'b1, 2'd0, 40'h0, 1'b0}, // R3
    '{40'h0012345680, 1'b0, 4'b1000, 1'b0, W_FL,    32'h12345680, 32'h0,        2'd0, 1'b0, 2'd0, 40'h0, 1'b0}, // R4
    '{40'h0022222230, 1'b1, 4'b1000, 1'b0, W_INV,   32'h77777700, 32'h30,       2'd0, 1'b0, 2'd0, 40'h0, 1'b0}, // R5
    '{40'h0033333340, 1'b1, 4'b1000, 1'b0, W_CLR,   32'h33333300, 32'h40,       2'd0, 1'b0, 2'd0, 40'h0, 1'b0}, // R6 hit
    '{40'h0033333350, 1'b1, 4'b1000, 1'b0, W_CLR,   32'h44444400, 32'h50,       2'd0, 1'b0, 2'd0, 40'h0, 1'b1}, // R6 miss
    '{40'hAB12345690, 1'b1, 4'b1010, 1'b0, W_CLREA, 32'h000000AB, 32'h12345690, 2'd0, 1'b0, 2'd0, 40'h0, 1'b0}, // R7 concat
    '{40'hAB12345690, 1'b1, 4'b1000, 1'b0, W_CLREA, 32'h000000AB, 32'h12345690, 2'd0, 1'b0, 2'd0, 40'h0, 1'b1}, // R7 EA off
    '{40'h00555555A0, 1'b1, 4'b1000, 1'b0, W_XFL,   32'h555555A0, 32'h0,        2'd2, 1'b0, 2'd0, 40'h0, 1'b1}, // R8
    '{40'h00666666B0, 1'b1, 4'b1001, 1'b0, W_EF,    32'h666666B0, 32'h0,        2'd0, 1'b1, 2'd0, 40'h0, 1'b0}, // R7 E ignored
    '{40'h00777777C0, 1'b1, 4'b0000, 1'b0, W_INV,   32'h777777C0, 32'hFFFFFFF0, 2'd0, 1'b0, 2'd0, 40'h0, 1'b0}, // R9
    '{40'h00888888D0, 1'b1, 4'b0001, 1'b0, W_XFL,   32'h88888800, 32'hD0,       2'd0, 1'b0, 2'd2, 40'h00888888D0, 1'b0}, // R10
    '{40'h00999999E0, 1'b1, 4'b0001, 1'b0, W_XCLR,  32'h999998E0, 32'h100,      2'd0, 1'b0, 2'd1, 40'h00999999E0, 1'b0}, // R10
    '{40'h00AAAAAAF0, 1'b1, 4'b0000, 1'b0, W_XCLR,  32'hAAAAAAF0, 32'h10,       2'd0, 1'b0, 2'd0, 40'h0, 1'b0}, // R9
    '{40'h00BBBBBB10, 1'b1, 4'b1100, 1'b1, W_FL,    32'hBBBBBB10, 32'h0,        2'd1, 1'b0, 2'd0, 40'h0, 1'b1}, // R2
    '{40'h00CCCCCC20, 1'b1, 4'b1000, 1'b1, W_FL,    32'hCCCCCC20, 32'h0,        2'd0, 1'b1, 2'd0, 40'h0, 1'b0}, // R2 no MMU
    '{40'h00DDDDDD40, 1'b1, 4'b1000, 1'b0, W_BAD,   32'hDDDDDD40, 32'h0,        2'd2, 1'b0, 2'd0, 40'h0, 1'b1}  // R1
  };

  int applied = 0, miscompares = 0;
  int beatCnt, extCnt, res;
  logic [39:0] wbAddr [4];
  logic [31:0] wbData [4];
  logic lastExtFlush;
  logic [39:0] lastExtAddr;

  // handshake partners: memory stalls every other cycle
  always @(posedge clk) begin
    #1;
    memReady <= ~memReady;
    extReady <= extValid;
  end

  always @(negedge clk) begin
    if (memValid && memReady) begin
      if (beatCnt < 4) begin wbAddr[beatCnt] = memAddr; wbData[beatCnt] = memData; end
      beatCnt++;
    end
    if (extValid && extReady) begin
      extCnt++; lastExtFlush = extFlush; lastExtAddr = extAddr;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pattern(input logic [39:0] a);
    logic [127:0] d;
    for (int w = 0; w < 4; w++) d[w*32 +: 32] = a[31:0] + 32'(w);
    return d;
  endfunction

  task automatic fillLine(input logic [39:0] a, input logic dty);
    @(negedge clk);
    fillEn = 1; fillAddr = a; fillDirty = dty; fillData = pattern(a);
    @(posedge clk); #1 fillEn = 0;
  endtask

  task automatic runCmd(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] cfg, input logic usr);
    @(negedge clk);
    beatCnt = 0; extCnt = 0; res = 3;
    cmdWord = w; opA = a; opB = b; userMode = usr;
    {cfgWriteBack, cfgMmu, cfgExtAddr, cfgExtCache} = cfg;
    cmdValid = 1;
    @(posedge clk); #1 cmdValid = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) begin res = 0; break; end
      if (privExc) begin res = 1; break; end
      if (illegal) begin res = 2; break; end
    end
  endtask

  // probe: flush in write-back mode; 4 beats means the dirty line survived
  task automatic probe(input logic [39:0] a, output int beats);
    runCmd(W_FL, a[31:0], 32'h0, 4'b1000, 1'b0);
    beats = beatCnt;
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    int pb;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(cmdReady == 1 && memValid == 0 && extValid == 0 && {done, privExc, illegal} == 0,
          "R13 idle outputs", {cmdReady, memValid, extValid, done, privExc, illegal}, 6'b100000);
    rstN = 1;
    probe(40'h0000000070, pb);
    check(pb == 0 && res == 0, "R13 lines invalid after reset", pb, 0);

    foreach (VEC[k]) begin
      fillLine(VEC[k].fAddr, VEC[k].fDirty);
      runCmd(VEC[k].iw, VEC[k].ra, VEC[k].rb, VEC[k].cfg, VEC[k].usr);
      check(res == int'(VEC[k].res), "R11 result pulse kind (R1 R2 R8)", res, VEC[k].res);
      check(beatCnt == (VEC[k].wb ? 4 : 0), "R3 write-back beat count", beatCnt, VEC[k].wb ? 4 : 0);
      if (VEC[k].wb) begin
        bit ok = 1;
        for (int j = 0; j < 4; j++)
          if (wbAddr[j] != VEC[k].fAddr + 40'(4*j) || wbData[j] != VEC[k].fAddr[31:0] + 32'(j)) ok = 0;
        check(ok, "R3 ascending beats address and data", wbAddr[3], VEC[k].fAddr + 40'd12);
      end
      check(extCnt == (VEC[k].ext != 0 ? 1 : 0), "R10 external request count", extCnt, VEC[k].ext != 0);
      if (VEC[k].ext != 0)
        check(lastExtFlush == (VEC[k].ext == 2) && lastExtAddr == VEC[k].extA,
              "R10 external kind and address", {lastExtFlush, lastExtAddr}, {VEC[k].ext == 2, VEC[k].extA});
      probe(VEC[k].fAddr, pb);
      check(pb == (VEC[k].alive ? 4 : 0), "R5 R6 R9 line state after command", pb, VEC[k].alive ? 4 : 0);
    end

    // R11 busy: cmdReady low while a write-back is pending
    fillLine(40'h0011111100, 1'b1);
    @(negedge clk);
    cmdWord = W_FL; opA = 32'h11111100; opB = 0; userMode = 0;
    {cfgWriteBack, cfgMmu, cfgExtAddr, cfgExtCache} = 4'b1000; cmdValid = 1;
    beatCnt = 0; extCnt = 0;
    @(posedge clk); #1 cmdValid = 0;
    @(negedge clk);
    check(cmdReady == 0 && done == 0, "R11 busy after accept", {cmdReady, done}, 2'b00);
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (done) break; end
    check(done == 1 && beatCnt == 4, "R11 done after last beat", beatCnt, 4);
    @(negedge clk);
    check(done == 0 && cmdReady == 1, "R11 single-cycle pulse", {done, cmdReady}, 2'b01);

    // R12 same-cycle fill and index-only invalidate on line 5: fill wins
    fillLine(40'h0012121250, 1'b1);
    @(negedge clk);
    beatCnt = 0;
    cmdWord = W_INV; opA = 32'h34343450; opB = 0; userMode = 0;
    {cfgWriteBack, cfgMmu, cfgExtAddr, cfgExtCache} = 4'b1000; cmdValid = 1;
    @(posedge clk); #1 cmdValid = 0;
    fillEn = 1; fillAddr = 40'h0056565650; fillDirty = 1; fillData = pattern(40'h0056565650);
    @(posedge clk); #1 fillEn = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (done) break; end
    check(done == 1, "R12 invalidate completes", done, 1);
    probe(40'h0000000050, pb);
    check(pb == 4 && wbAddr[0] == 40'h0056565650 && wbData[0] == 32'h56565650,
          "R12 fill wins over same-cycle clear", wbAddr[0], 40'h0056565650);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule